// File: doc/BRIEF.md
# Dual Preloadable Timer/Event Counter

Two identical 16-bit up-counters sit behind one small byte-wide register port. Each counter has a reload value. A counter can count a prescaled copy of the system clock, count edges on its own external input, or measure how long that input stays at a chosen level. When a counter rolls past all ones, it reloads itself and raises a one-cycle event. That event serves as a wake-up strobe and, if enabled, as an interrupt request. The event also flips a divided square wave.

One of the two square waves, chosen by a static parameter, can be driven onto a shared output pin. A software-controlled enable bit gates the pin. Software loads the reload bytes first, then sets the run bit. A counter that is stopped takes a reload-byte write into its count at once. A running counter keeps counting until its next rollover.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset, every control register, count, reload value and the pin enable read back as zero, and irq_req, wake_req and div_pin are low.
- R2: A write to a reload byte while the counter's run bit is 0 also sets that byte of the count on the next clock. While the run bit is 1, the same write changes only the reload value, and the count goes on untouched.
- R3: When a count step takes the count past 16'hFFFF, the count becomes the reload value and wake_req of that counter is high for exactly one cycle.
- R4: The interrupt-enable bit (control bit 5) gates irq_req. irq_req is high only together with wake_req. With the bit at 0, the rollover and reload still take place.
- R5: The count advances only while the run bit (control bit 4) is 1 and the mode field (control bits 7:6) is not 00.
- R6: In timer mode (mode 10), the count steps once every 2^(s+1) system clocks, where s is the tap field (control bits 2:0). A reload value P therefore gives one rollover every (65536-P)*2^(s+1) clocks.
- R7: In event mode (mode 01), the count steps once per edge of the counter's external input. Edge select (control bit 3) picks the edge: 0 counts rising edges and 1 counts falling edges. The input passes through two synchronizing flops, so the count reflects an input change after the third rising clock edge.
- R8: In pulse-width mode (mode 11), with edge select 0 for a high pulse and 1 for a low pulse, counting starts at the first active edge after run is set. The count steps on prescaled ticks while the input stays active. The inactive edge that follows stops counting and clears the run bit in hardware.
- R9: In any cycle in which the bus reads a count byte of a counter (bus_rd with address low bits 01 or 10), that counter's count does not change.
- R10: Each counter's divider output starts low and flips on each of its rollovers. div_pin equals the divider output of the counter chosen by PIN_SRC while the pin enable is 1, and is 0 otherwise.
- R11: Register map: bus_addr[2] selects the counter. bus_addr[1:0] selects a register: 00 is control, 01 is the count low byte (read) and reload low byte (write), 10 is the count high byte (read) and reload high byte (write), and 11 is the shared pin enable in bit 0. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (freezes a count byte read) |
| bus_addr | input | 3 | Counter select (bit 2) and register select (bits 1:0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_in | input | 2 | External event/pulse input, one per counter |
| irq_req | output | 2 | Rollover interrupt request pulse, one per counter |
| wake_req | output | 2 | Rollover wake-up pulse, one per counter |
| div_pin | output | 1 | Shared divided-frequency output pin |

## Verification
A register write is visible on bus_rdata one clock later. A rollover shows on wake_req and irq_req in the cycle right after the edge that wrapped the count, and the divider flips at that same edge. An external input change reaches the count at the third rising edge. The bench drives on falling edges and samples half a cycle after the edge that is due. It checks input-driven counts only after at least five quiet cycles. A scoreboard queue holds the expected rollover spacing and interrupt state, and the monitor compares them at each wake pulse. This keeps the period checks exact to the clock even though the prescaler phase is free-running.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the dual timer/event counter.
// Assumes control register bits are laid out as listed below.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2,
        REG_PIN  = 2'd3
    } reg_sel_e;

    localparam int EDGE_BIT = 3;
    localparam int RUN_BIT  = 4;
    localparam int IEN_BIT  = 5;
    localparam int MODE_LSB = 6;
endpackage

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
// Free-running prescaler with a selectable tap.
// tick is a one-cycle pulse every 2^(tap_sel+1) clocks.
// Assumes tap_sel < STAGES.
module tmr_presc #(
    parameter int STAGES = 8,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tick
);
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] tap_mask;

    // Ripple stage counter, restarted by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_q + 1'b1;
    end

    // Mask of the stages that must all be ones for the chosen tap.
    always_comb begin
        for (int k = 0; k < STAGES; k++) begin
            tap_mask[k] = (k <= int'(tap_sel));
        end
    end

    assign tick = &(stage_q | ~tap_mask);
endmodule

// File: rtl/tmr_insync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus edge detector for an external input.
// Edges are reported relative to the active level chosen by edge_sel
// (0: high is active, 1: low is active). Each edge flag lasts one cycle.
module tmr_insync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic edge_sel,
    output logic act_edge,
    output logic inact_edge
);
    logic [2:0] pipe_q;
    logic       lvl_now;
    logic       lvl_prev;

    // Shift the raw input through sync and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[1:0], din};
    end

    assign lvl_now    = pipe_q[1] ^ edge_sel;
    assign lvl_prev   = pipe_q[2] ^ edge_sel;
    assign act_edge   = lvl_now & ~lvl_prev;
    assign inact_edge = ~lvl_now & lvl_prev;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
// One preloadable counter with its control and reload registers.
// Assumes at most one register write strobe per cycle.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int STAGES = 8,
    parameter int SEL_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic                  lo_we,
    input  logic                  hi_we,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  freeze,
    input  logic                  ext_in,
    output logic [BYTE_W-1:0]     ctrl_o,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output logic                  wake_o,
    output logic                  irq_o,
    output logic                  div_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  pre_q, pre_nx, cnt_q;
    logic              pw_on_q, ovf_q, irq_q, div_q;
    tmr_mode_e         mode;
    logic              run, ien, edge_sel;
    logic              presc_tick, act_edge, inact_edge;
    logic              src, tick, wrap, pw_done;

    assign mode     = tmr_mode_e'(ctrl_q[MODE_LSB +: 2]);
    assign run      = ctrl_q[RUN_BIT];
    assign ien      = ctrl_q[IEN_BIT];
    assign edge_sel = ctrl_q[EDGE_BIT];

    tmr_presc #(.STAGES(STAGES), .SEL_W(SEL_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_sel (ctrl_q[SEL_W-1:0]),
        .tick    (presc_tick)
    );

    tmr_insync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (ext_in),
        .edge_sel   (edge_sel),
        .act_edge   (act_edge),
        .inact_edge (inact_edge)
    );

    // Pick the count source for the current mode.
    always_comb begin
        case (mode)
            MODE_EVENT: src = act_edge;
            MODE_TIMER: src = presc_tick;
            MODE_PULSE: src = presc_tick & pw_on_q;
            default:    src = 1'b0;
        endcase
    end

    assign tick    = run & ~freeze & src;
    assign wrap    = tick & (&cnt_q);
    assign pw_done = run & (mode == MODE_PULSE) & pw_on_q & inact_edge;

    // Reload value as it will stand after this cycle's byte writes.
    always_comb begin
        pre_nx = pre_q;
        if (lo_we) pre_nx[BYTE_W-1:0]     = wdata;
        if (hi_we) pre_nx[CNT_W-1:BYTE_W] = wdata;
    end

    // Control register: software write wins over the hardware run clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
        else if (pw_done) ctrl_q[RUN_BIT] <= 1'b0;
    end

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_nx;
    end

    // Count register: direct load when stopped, reload on wrap, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if ((lo_we | hi_we) & ~run) cnt_q <= pre_nx;
        else if (wrap)                   cnt_q <= pre_q;
        else if (tick)                   cnt_q <= cnt_q + 1'b1;
    end

    // Pulse-width window: opens on an active edge, closes on the inactive one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || mode != MODE_PULSE) pw_on_q <= 1'b0;
        else if (!pw_on_q && act_edge)            pw_on_q <= 1'b1;
        else if (inact_edge)                      pw_on_q <= 1'b0;
    end

    // Rollover event, gated request and divider flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
            div_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            irq_q <= wrap & ien;
            div_q <= div_q ^ wrap;
        end
    end

    assign ctrl_o = ctrl_q;
    assign cnt_o  = cnt_q;
    assign wake_o = ovf_q;
    assign irq_o  = irq_q;
    assign div_o  = div_q;
endmodule

// File: rtl/tmr_pair_top.sv
`timescale 1ns/1ps
// Two timer/event counters behind one byte register port, plus a
// shared divider pin. PIN_SRC is a static choice of which counter
// feeds the pin. Reads are combinational. Assumes one access per cycle.
module tmr_pair_top
    import tmr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int STAGES  = 8,
    parameter int SEL_W   = 3,
    parameter int PIN_SRC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        ext_in,
    output logic [1:0]        irq_req,
    output logic [1:0]        wake_req,
    output logic              div_pin
);
    localparam int NUM_TMR = 2;
    localparam int CNT_W   = 2 * BYTE_W;

    reg_sel_e                         reg_sel;
    logic                             tmr_idx;
    logic                             pin_en_q;
    logic [NUM_TMR-1:0][BYTE_W-1:0]   ctrl_all;
    logic [NUM_TMR-1:0][CNT_W-1:0]    cnt_all;
    logic [NUM_TMR-1:0]               div_bits;

    assign reg_sel = reg_sel_e'(bus_addr[1:0]);
    assign tmr_idx = bus_addr[2];

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic hit;
        assign hit = (int'(tmr_idx) == i);

        tmr_core #(.BYTE_W(BYTE_W), .STAGES(STAGES), .SEL_W(SEL_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (bus_wr & hit & (reg_sel == REG_CTRL)),
            .lo_we   (bus_wr & hit & (reg_sel == REG_LOW)),
            .hi_we   (bus_wr & hit & (reg_sel == REG_HIGH)),
            .wdata   (bus_wdata),
            .freeze  (bus_rd & hit & ((reg_sel == REG_LOW) || (reg_sel == REG_HIGH))),
            .ext_in  (ext_in[i]),
            .ctrl_o  (ctrl_all[i]),
            .cnt_o   (cnt_all[i]),
            .wake_o  (wake_req[i]),
            .irq_o   (irq_req[i]),
            .div_o   (div_bits[i])
        );
    end

    // Shared pin enable, writable through either counter's window.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pin_en_q <= 1'b0;
        else if (bus_wr && reg_sel == REG_PIN)  pin_en_q <= bus_wdata[0];
    end

    // Read data mux.
    always_comb begin
        case (reg_sel)
            REG_CTRL: bus_rdata = ctrl_all[tmr_idx];
            REG_LOW:  bus_rdata = cnt_all[tmr_idx][BYTE_W-1:0];
            REG_HIGH: bus_rdata = cnt_all[tmr_idx][CNT_W-1:BYTE_W];
            default:  bus_rdata = {{(BYTE_W-1){1'b0}}, pin_en_q};
        endcase
    end

    assign div_pin = pin_en_q & div_bits[PIN_SRC];
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
// Property checker for tmr_pair_top, attached by bind below.
module tmr_pair_chk
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [2:0]                bus_addr,
    input logic [1:0][BYTE_W-1:0]    ctrl_all,
    input logic [1:0][2*BYTE_W-1:0]  cnt_all,
    input logic [1:0]                wake_req,
    input logic [1:0]                irq_req,
    input logic [1:0]                div_bits,
    input logic                      pin_en,
    input logic                      div_pin
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R3
        wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake_req[i] |=> !wake_req[i]);
        // R4
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> wake_req[i]);
        // R10
        div_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake_req[i] |-> (div_bits[i] != $past(div_bits[i])));
        // R10
        div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wake_req[i] |-> $stable(div_bits[i]));
        // R5
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_all[i][RUN_BIT] && !bus_wr) |=> $stable(cnt_all[i]));
        // R9
        read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && int'(bus_addr[2]) == i &&
             (bus_addr[1:0] == 2'd1 || bus_addr[1:0] == 2'd2)) |=> $stable(cnt_all[i]));
    end

    // R10
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> !div_pin);
endmodule

bind tmr_pair_top tmr_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .ctrl_all (ctrl_all),
    .cnt_all  (cnt_all),
    .wake_req (wake_req),
    .irq_req  (irq_req),
    .div_bits (div_bits),
    .pin_en   (pin_en_q),
    .div_pin  (div_pin)
);

// File: tb/tb_tmr_pair_top.sv
`timescale 1ns/1ps
module tb_tmr_pair_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ext_in = '0;
    logic [1:0] irq_req;
    logic [1:0] wake_req;
    logic       div_pin;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_stamp = 0;
    bit finished = 1'b0;

    typedef struct { int gap; bit irq; } ovf_item_t;
    ovf_item_t exp_q[$];
    ovf_item_t cur;

    tmr_pair_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_in(ext_in), .irq_req(irq_req), .wake_req(wake_req), .div_pin(div_pin)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_wake();
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (wake_req[0]) break;
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 3000 && exp_q.size() > 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    endtask

    // Monitor: pop one expected rollover per wake pulse of counter 0.
    always @(negedge clk) begin
        if (rst_n && wake_req[0] && exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            if (cur.gap >= 0) begin
                check(cyc - last_stamp == cur.gap, "R6 rollover period", cyc - last_stamp, cur.gap);
                check(irq_req[0] == cur.irq, "R4 irq gating", int'(irq_req[0]), int'(cur.irq));
            end
            last_stamp = cyc;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v0;
        int errs, d1, d2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 map
        rd(3'd0, v); check(v == 8'h00, "R1 ctrl0 reset", v, 0);
        rd(3'd1, v); check(v == 8'h00, "R1 count low reset", v, 0);
        rd(3'd2, v); check(v == 8'h00, "R1 count high reset", v, 0);
        rd(3'd3, v); check(v == 8'h00, "R1 R11 pin enable reset", v, 0);
        rd(3'd4, v); check(v == 8'h00, "R1 ctrl1 reset", v, 0);
        check(wake_req == 2'b00 && irq_req == 2'b00 && !div_pin, "R1 outputs low",
              {wake_req, irq_req, div_pin}, 0);

        // R2 stopped write loads count
        wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        rd(3'd1, v); check(v == 8'h34, "R2 stopped load low", v, 8'h34);
        rd(3'd2, v); check(v == 8'h12, "R2 R11 stopped load high", v, 8'h12);

        // R5 mode off with run set, then timer mode with run clear
        wr(3'd0, 8'h10); wait_cyc(20);
        rd(3'd1, v); check(v == 8'h34, "R5 mode off holds", v, 8'h34);
        wr(3'd0, 8'h82); wait_cyc(20);
        rd(3'd1, v); check(v == 8'h34, "R5 run clear holds", v, 8'h34);

        // R6 timer periods with interrupt enabled (tap 2, reload FFFC)
        wr(3'd1, 8'hFC); wr(3'd2, 8'hFF);
        rd(3'd1, v); check(v == 8'hFC, "R2 stopped reload", v, 8'hFC);
        wr(3'd0, 8'hB2);
        exp_q.push_back('{-1, 1'b0});
        exp_q.push_back('{32, 1'b1});
        exp_q.push_back('{32, 1'b1});
        drain();

        // R10 pin stays low while disabled
        errs = 0;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            if (div_pin) errs++;
        end
        check(errs == 0, "R10 pin low when disabled", errs, 0);

        // R10 pin follows the divider and flips per rollover
        wr(3'd3, 8'h01);
        wait_wake(); d1 = int'(div_pin);
        wait_wake(); d2 = int'(div_pin);
        check(d2 != d1, "R10 divider flips", d2, 1 - d1);

        // R4 interrupt disabled, reload still happens
        wr(3'd0, 8'h92);
        exp_q.push_back('{-1, 1'b0});
        exp_q.push_back('{32, 1'b0});
        drain();

        // R3 reload value and single-cycle wake
        wait_wake();
        @(negedge clk);
        check(!wake_req[0], "R3 wake one cycle", int'(wake_req[0]), 0);
        rd(3'd1, v); check(v == 8'hFC, "R3 reload value", v, 8'hFC);

        // R2 running write leaves the count alone, new reload used later
        wait_wake();
        wr(3'd1, 8'hF0);
        rd(3'd1, v); check(v >= 8'hFC && v <= 8'hFE, "R2 running write keeps count", v, 8'hFC);
        exp_q.push_back('{-1, 1'b0});
        exp_q.push_back('{128, 1'b0});
        drain();

        // R9 count frozen during reads (tap 0)
        wr(3'd0, 8'h90); wait_cyc(3);
        @(negedge clk);
        bus_addr = 3'd1; bus_rd = 1'b1;
        #1 v0 = bus_rdata;
        errs = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            #1 if (bus_rdata != v0) errs++;
        end
        @(negedge clk); bus_rd = 1'b0;
        check(errs == 0, "R9 frozen during read", errs, 0);
        wait_cyc(4);
        rd(3'd1, v); check(v != v0, "R9 resumes after read", v, v0 + 1);

        // R10 pin disabled again while divider keeps running
        wr(3'd3, 8'h00);
        errs = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (div_pin) errs++;
        end
        check(errs == 0, "R10 pin gated off", errs, 0);

        // R7 event mode on counter 1, rising then falling edges
        wr(3'd5, 8'h00); wr(3'd6, 8'h00);
        wr(3'd4, 8'h50);
        repeat (5) begin ext_in[1] = 1'b1; wait_cyc(4); ext_in[1] = 1'b0; wait_cyc(4); end
        wait_cyc(5);
        rd(3'd5, v); check(v == 8'd5, "R7 rising edges", v, 5);
        wr(3'd4, 8'h40); wr(3'd5, 8'h00);
        wr(3'd4, 8'h58);
        repeat (3) begin ext_in[1] = 1'b1; wait_cyc(4); ext_in[1] = 1'b0; wait_cyc(4); end
        wait_cyc(5);
        rd(3'd5, v); check(v == 8'd3, "R7 falling edges", v, 3);

        // R8 pulse-width mode: 40-cycle high pulse at tap 0 gives 20
        wr(3'd4, 8'hC0); wr(3'd5, 8'h00);
        wr(3'd4, 8'hD0); wait_cyc(3);
        ext_in[1] = 1'b1; wait_cyc(40); ext_in[1] = 1'b0; wait_cyc(6);
        rd(3'd5, v); check(v == 8'd20, "R8 measured width", v, 20);
        rd(3'd4, v); check(v == 8'hC0, "R8 run cleared by hardware", v, 8'hC0);
        ext_in[1] = 1'b1; wait_cyc(20); ext_in[1] = 1'b0; wait_cyc(6);
        rd(3'd5, v); check(v == 8'd20, "R8 no count after completion", v, 20);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule